// File: doc/BRIEF.md
# Synchronizing Additive Stream Descrambler

This block recovers plain data from a serial line that was scrambled by XOR with the output of an 11-stage linear feedback shift register. The keystream follows k[n] = k[n-9] XOR k[n-11]. The block takes one received bit per clock when `bit_vld` is high. It produces the descrambled bit and a hypothetical-data bit, both registered, together with an output strobe.

The hypothetical-data bit is the received bit XOR the received bits 9 and 11 positions back. While the far end sends idle ones, this bit reads 1. A separate line-state monitor watches it and raises `hold_req` once it has seen enough idle.

The block works in one of two modes:
- **Sample mode.** A local key register is loaded with each received bit XOR the idle value. While idle is on the line, that is exactly the far-end keystream.
- **Hold mode.** The key register closes its feedback loop and runs as a free LFSR locked to the far-end scrambler.

When `hold_req` drops, the block falls back to sample mode and waits for the next hold to resynchronise. Hold mode is only entered, and only kept, while the key register's next content is nonzero, so the LFSR can never sit in its lock-up state.

Top module: `sync_descrambler`

## Requirements
- R1: After a synchronous active-high reset, `dout`, `hyp_bit`, `dout_vld` and `locked` are all 0, and both internal histories are cleared.
- R2: In hold mode the key register advances by its own feedback (newest key = key[n-9] XOR key[n-11]), so a payload scrambled from any nonzero seed is recovered bit for bit after lock.
- R3: For every cycle with `bit_vld` high, `dout` = received bit XOR (key[n-9] XOR key[n-11]) appears one clock later, with `dout_vld` high for exactly that one clock.
- R4: In sample mode each valid bit loads (received bit XOR idle value 1) into the key register, so `dout` equals `hyp_bit` and reads 1 on idle once 11 bits have arrived.
- R5: `hyp_bit` = received bit XOR received[n-9] XOR received[n-11], one clock after the bit, in both modes; it reads 1 throughout an all-ones idle stream after the first 11 bits.
- R6: `locked` at the next edge equals `hold_req` AND (the key register's next content is nonzero); a low `hold_req` returns the block to sample mode after one edge.
- R7: A hold request while the key register would be all zero is refused: `locked` stays 0 until a received bit makes the key nonzero, and `locked` is never 1 with an all-zero key register.
- R8: A cycle with `bit_vld` low shifts neither history, leaves `dout` and `hyp_bit` unchanged and drives `dout_vld` low.
- R9: A single corrupted line bit produces one wrong `dout` bit in hold mode, but three (at offsets 0, 9 and 11) in sample mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Received bit is valid this cycle |
| rx_bit | input | 1 | Received scrambled bit |
| hold_req | input | 1 | Hold request from the line-state monitor |
| dout | output | 1 | Descrambled bit |
| dout_vld | output | 1 | `dout` and `hyp_bit` were updated this cycle |
| hyp_bit | output | 1 | Hypothetical-data bit for the monitor |
| locked | output | 1 | 1 in hold mode, 0 in sample mode |

## Verification
Two functions can meet in one cycle: the mode decision and the key register shift. Both act on the same valid bit, so a hold request can arrive in the very cycle whose shift would leave the key register all zero. The bench provokes this right after reset by raising `hold_req` while feeding received ones, which imply a zero keystream. It then feeds a single zero. `locked` must stay low through the ones and rise on exactly the edge that loads the first nonzero key bit. A behavioural model with its own histories judges every cycle of this sequence, together with the idle-to-hold handover and the return to sample mode.

// File: rtl/sdsc_pkg.sv
package sdsc_pkg;

    parameter int unsigned TAP_NEAR_DEF = 9;
    parameter int unsigned TAP_FAR_DEF  = 11;
    parameter bit          IDLE_DEF     = 1'b1;

    typedef enum logic {
        MODE_SAMPLE = 1'b0,
        MODE_HOLD   = 1'b1
    } mode_e;

    typedef struct packed {
        logic data;
        logic hyp;
    } out_pair_t;

    function automatic logic key_in_sel(mode_e m, logic fb, logic rx, logic idle);
        return (m == MODE_HOLD) ? fb : (rx ^ idle);
    endfunction

endpackage

// File: rtl/sdsc_shreg.sv
module sdsc_shreg #(
    parameter int unsigned TAP_NEAR = 9,
    parameter int unsigned TAP_FAR  = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_en,
    input  logic               din,
    output logic [TAP_FAR-1:0] q,
    output logic               tap,
    output logic               nz_next
);
    localparam int unsigned WIDTH = TAP_FAR;

    logic [WIDTH-1:0] q_next;

    always_comb begin
        q_next = shift_en ? {q[WIDTH-2:0], din} : q;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_next;
    end

    assign tap     = q[TAP_NEAR-1] ^ q[TAP_FAR-1];
    assign nz_next = |q_next;

    // R8: no shift when no valid bit
    a_r8_frozen_when_idle: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(q));

endmodule

// File: rtl/sdsc_mode.sv
module sdsc_mode (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold_req,
    input  logic            key_nz_next,
    output sdsc_pkg::mode_e mode
);
    import sdsc_pkg::*;

    always_ff @(posedge clk) begin
        if (rst)                          mode <= MODE_SAMPLE;
        else if (hold_req && key_nz_next) mode <= MODE_HOLD;
        else                              mode <= MODE_SAMPLE;
    end

    // R6: release of the hold request ends hold mode after one edge
    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        !hold_req |=> mode == MODE_SAMPLE);

    // R7: a zero next key never leads into hold
    a_r7_refuse_zero: assert property (@(posedge clk) disable iff (rst)
        !key_nz_next |=> mode == MODE_SAMPLE);

endmodule

// File: rtl/sync_descrambler.sv
module sync_descrambler #(
    parameter int unsigned TAP_NEAR = sdsc_pkg::TAP_NEAR_DEF,
    parameter int unsigned TAP_FAR  = sdsc_pkg::TAP_FAR_DEF,
    parameter bit          IDLE_BIT = sdsc_pkg::IDLE_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic rx_bit,
    input  logic hold_req,
    output logic dout,
    output logic dout_vld,
    output logic hyp_bit,
    output logic locked
);
    import sdsc_pkg::*;

    localparam int unsigned HIST_W = TAP_FAR;

    logic [HIST_W-1:0] rx_q;
    logic [HIST_W-1:0] key_q;
    logic              rx_tap, key_tap;
    logic              rx_nz, key_nz;
    logic              key_din;
    mode_e             mode;
    out_pair_t         obuf;

    assign key_din = key_in_sel(mode, key_tap, rx_bit, IDLE_BIT);

    // history of received bits, feeds the hypothetical-data path
    sdsc_shreg #(.TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR)) u_rx_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (bit_vld),
        .din      (rx_bit),
        .q        (rx_q),
        .tap      (rx_tap),
        .nz_next  (rx_nz)
    );

    // local key register: sampled in sample mode, free LFSR in hold mode
    sdsc_shreg #(.TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR)) u_key (
        .clk      (clk),
        .rst      (rst),
        .shift_en (bit_vld),
        .din      (key_din),
        .q        (key_q),
        .tap      (key_tap),
        .nz_next  (key_nz)
    );

    sdsc_mode u_mode (
        .clk         (clk),
        .rst         (rst),
        .hold_req    (hold_req),
        .key_nz_next (key_nz),
        .mode        (mode)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            obuf     <= '0;
            dout_vld <= 1'b0;
        end else begin
            dout_vld <= bit_vld;
            if (bit_vld) begin
                obuf.data <= rx_bit ^ key_tap;
                obuf.hyp  <= rx_bit ^ rx_tap;
            end
        end
    end

    assign dout    = obuf.data;
    assign hyp_bit = obuf.hyp;
    assign locked  = (mode == MODE_HOLD);

    // R7: hold mode never runs on an all-zero key
    a_r7_no_zero_in_hold: assert property (@(posedge clk) disable iff (rst)
        locked |-> (key_q != '0));

    // R3: output strobe follows each valid bit by one clock
    a_r3_vld_follows: assert property (@(posedge clk) disable iff (rst)
        bit_vld |=> dout_vld);
    a_r3_vld_quiet: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |=> !dout_vld);

    // R4: sample mode loads received bit XOR idle value
    a_r4_sample_load: assert property (@(posedge clk) disable iff (rst)
        (!locked && bit_vld) |=> key_q[0] == ($past(rx_bit) ^ IDLE_BIT));

    // R2: hold mode loads its own feedback
    a_r2_hold_feedback: assert property (@(posedge clk) disable iff (rst)
        (locked && bit_vld) |=>
            key_q[0] == ($past(key_q[TAP_NEAR-1]) ^ $past(key_q[TAP_FAR-1])));

    // R8: received history unchanged in idle cycles
    a_r8_rx_hist_idle: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |-> (rx_nz == (|rx_q)));

endmodule

// File: tb/sync_descrambler_test.sv
module sync_descrambler_test;

    logic clk = 1'b0;
    logic rst, bit_vld, rx_bit, hold_req;
    logic dout, dout_vld, hyp_bit, locked;

    always #4 clk = ~clk;   // 125 MHz

    sync_descrambler uut (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .rx_bit(rx_bit),
        .hold_req(hold_req), .dout(dout), .dout_vld(dout_vld),
        .hyp_bit(hyp_bit), .locked(locked)
    );

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    // behavioural model state, index 0 = newest
    bit  mrx[11];
    bit  mkey[11];
    bit  ks[11];
    logic e_dout, e_hyp, e_vld, e_lock;
    bit  last_mism;

    task automatic chk(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 11; i++) begin mrx[i] = 1'b0; mkey[i] = 1'b0; end
        e_dout = 1'b0; e_hyp = 1'b0; e_vld = 1'b0; e_lock = 1'b0;
    endtask

    task automatic step(input logic v, input logic b, input logic h);
        bit fb, nb, nz;
        @(negedge clk);
        bit_vld = v; rx_bit = b; hold_req = h;
        if (v) begin
            fb     = mkey[8] ^ mkey[10];
            e_dout = b ^ fb;
            e_hyp  = b ^ mrx[8] ^ mrx[10];
            e_vld  = 1'b1;
            nb     = e_lock ? fb : ~b;
            for (int i = 10; i > 0; i--) begin mkey[i] = mkey[i-1]; mrx[i] = mrx[i-1]; end
            mkey[0] = nb;
            mrx[0]  = b;
        end else begin
            e_vld = 1'b0;
        end
        nz = 1'b0;
        for (int i = 0; i < 11; i++) nz = nz | mkey[i];
        e_lock = h & nz;
        @(posedge clk);
        #1;
        chk({locked, dout_vld, hyp_bit, dout} === {e_lock, e_vld, e_hyp, e_dout},
            "R3 R5 R6 R8 model", {locked, dout_vld, hyp_bit, dout}, {e_lock, e_vld, e_hyp, e_dout});
        if (!v) chk(dout_vld === 1'b0, "R8 gap", {3'b0, dout_vld}, 4'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bit_vld = 1'b0; rx_bit = 1'b0; hold_req = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
        #1;
        chk({locked, dout_vld, hyp_bit, dout} === 4'b0, "R1 reset",
            {locked, dout_vld, hyp_bit, dout}, 4'b0);
    endtask

    task automatic seed_scrambler(input logic [10:0] s);
        for (int i = 0; i < 11; i++) ks[i] = s[i];
    endtask

    // scrambles one plain bit, sends it, flags mismatch at dout
    task automatic send(input bit plain, input bit flip, input bit h);
        bit k;
        k = ks[8] ^ ks[10];
        for (int i = 10; i > 0; i--) ks[i] = ks[i-1];
        ks[0] = k;
        step(1'b1, plain ^ k ^ flip, h);
        last_mism = (dout !== plain);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [10:0] seed;
        int mism;
        bit  pb;
        rst = 1'b1; bit_vld = 1'b0; rx_bit = 1'b0; hold_req = 1'b0;
        model_clear();

        // R1 reset state
        do_reset();

        // R7: hold refused while received ones imply a zero key
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 1'b1, 1'b1);
            chk(locked === 1'b0, "R7 refuse zero key", {3'b0, locked}, 4'b0);
        end
        step(1'b1, 1'b0, 1'b1);
        chk(locked === 1'b1, "R7 R6 lock on first nonzero key", {3'b0, locked}, 4'b1);
        step(1'b0, 1'b0, 1'b0);
        chk(locked === 1'b0, "R6 release", {3'b0, locked}, 4'b0);

        // idle acquisition with random nonzero seed
        do_reset();
        seed = 11'($urandom(32'h5EED) & 32'h7FF);
        if (seed == 11'd0) seed = 11'd1;
        seed_scrambler(seed);
        for (int i = 0; i < 100; i++) begin
            if (i % 7 == 3) step(1'b0, 1'b0, i >= 40);
            send(1'b1, 1'b0, i >= 40);
            if (i >= 11) begin
                chk(hyp_bit === 1'b1, "R5 idle hyp", {3'b0, hyp_bit}, 4'b1);
                chk(dout === 1'b1, "R4 idle dout", {3'b0, dout}, 4'b1);
            end
            if (i >= 41) chk(locked === 1'b1, "R6 locked", {3'b0, locked}, 4'b1);
        end

        // R2 payload after lock
        for (int i = 0; i < 200; i++) begin
            if (i % 5 == 2) step(1'b0, 1'b0, 1'b1);
            pb = 1'($urandom & 1);
            send(pb, 1'b0, 1'b1);
            chk(!last_mism, "R2 payload", {3'b0, dout}, {3'b0, pb});
        end

        // R9 single error in hold mode
        mism = 0;
        for (int i = 0; i < 21; i++) begin
            pb = 1'($urandom & 1);
            send(pb, i == 0, 1'b1);
            if (last_mism) mism++;
        end
        chk(mism == 1, "R9 hold error count", 4'(mism), 4'd1);

        // back to sample mode
        for (int i = 0; i < 20; i++) send(1'b1, 1'b0, 1'b1);
        send(1'b1, 1'b0, 1'b0);
        chk(locked === 1'b0, "R6 drop to sample", {3'b0, locked}, 4'b0);
        for (int i = 0; i < 15; i++) send(1'b1, 1'b0, 1'b0);

        // R9 single error in sample mode spreads to three bits
        mism = 0;
        for (int i = 0; i < 21; i++) begin
            send(1'b1, i == 0, 1'b0);
            if (last_mism) mism++;
        end
        chk(mism == 3, "R9 sample error count", 4'(mism), 4'd3);

        // resynchronise and recover payload again
        for (int i = 0; i < 20; i++) send(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 50; i++) begin
            pb = 1'($urandom & 1);
            send(pb, 1'b0, 1'b1);
            chk(!last_mism, "R2 payload after resync", {3'b0, dout}, {3'b0, pb});
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule